// File: doc/BRIEF.md
# Programmable Routing Connection Block

This block joins one routing channel of `W` tracks to the pins of a single logic cluster. Each cluster input pin has a selector that can pick one track from a small fixed group. Each cluster output pin can take over a small fixed group of tracks. On a track it does not take over, the upstream value passes through unchanged. The size of each group comes from a flexibility figure given in percent of the channel width, `FC_PCT`. Group size is `K = round(W*FC_PCT/100)`, clamped to the range 1..W. Pin `p` may reach tracks `(p+k) mod W` for `k = 0..K-1`, so pins with neighbouring numbers are staggered across the channel.

All routing choices sit in one serial configuration chain. It is shifted in one bit per clock while `cfg_en` is high. The data paths from tracks to pins and from pins to tracks are purely combinational. The settings take effect as soon as the chain bits hold them.

With the defaults `W=6`, `NIN=4`, `NOUT=2` and `FC_PCT=50`, the derived values are:
- `K=3`
- index width `IDXW=2`
- input field width `IW=3`
- chain length `L=18`

Top module: `cb_connect_block`

## Requirements
- R1: While `rst_n` is low, every chain bit is cleared. After reset, with no configuration loaded, every `pin_to_cluster` bit is 0 and `trk_out` equals `trk_in`.
- R2: On each rising clock edge with `cfg_en` high, the chain shifts toward higher bit numbers and `cfg_din` enters bit 0. `cfg_dout` is bit `L-1`. With `cfg_en` low, the chain holds its value.
- R3: Each pin reaches `K = round(W*FC_PCT/100)` tracks, clamped to 1..W. Pin `p`'s group is tracks `(p+k) mod W` for `k = 0..K-1`.
- R4: Input pin `p` owns chain bits `[p*IW +: IW]`, where `IW = IDXW+1`. The top bit of the field is the enable and the low `IDXW` bits are the index `k`. When enabled with `k < K`, `pin_to_cluster[p]` equals `trk_in[(p+k) mod W]`.
- R5: An input pin whose enable bit is 0, or whose index is `K` or more, drives 0.
- R6: Output pin `q` owns chain bits `[NIN*IW + q*K +: K]`. Setting bit `k` of that field lets the pin drive track `(q+k) mod W`. A track driven this way outputs `pin_from_cluster[q]` in place of its upstream value.
- R7: A track that no enabled output pin drives passes `trk_in` through to `trk_out`.
- R8: When several output pins are enabled on the same track, the lowest-numbered pin drives it.
- R9: Track-to-pin and pin-to-track paths are combinational. With the configuration fixed, changes on `trk_in` or `pin_from_cluster` appear on the outputs without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Active-low reset; clears the chain |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out (last chain stage) |
| trk_in | input | W | Upstream values of the channel tracks |
| trk_out | output | W | Downstream values of the channel tracks |
| pin_to_cluster | output | NIN | Values delivered to the cluster input pins |
| pin_from_cluster | input | NOUT | Values coming from the cluster output pins |

## Verification
The bench goes after three groups of corner cases.

First, it walks every input-pin field through all eight codes against every track pattern. This includes the index value 3, which lies past `K`. A selector that decodes that code as a track would put a live value on a pin that must read 0. A stagger computed without the wrap would pick the wrong track for pins near the channel edge.

Second, every combination of output enables is loaded and checked against all track and pin patterns. This exposes a priority that favours the higher pin and a track that is lost when no driver is enabled.

Third, the serial chain is read back bit by bit and left idle across clocks. This catches a reversed shift direction, an off-by-one stage count, and a chain that drifts while `cfg_en` is low.

// File: rtl/cb_pkg.sv
package cb_pkg;
  // Group size per pin: rounded fraction of the channel, clamped to 1..W
  function automatic int reach_of(input int w, input int pct);
    int r;
    r = (w * pct + 50) / 100;
    if (r < 1) r = 1;
    if (r > w) r = w;
    return r;
  endfunction

  // Track reached by pin p at step k of its group
  function automatic int track_of(input int p, input int k, input int w);
    return (p + k) % w;
  endfunction

  // Step at which pin q would reach track t (value >= group size means no reach)
  function automatic int offset_of(input int t, input int q, input int w);
    return ((t - (q % w)) + w) % w;
  endfunction

  function automatic int idx_width(input int k);
    return (k > 1) ? $clog2(k) : 1;
  endfunction
endpackage

// File: rtl/cb_cfg_chain.sv
module cb_cfg_chain #(
  parameter int L = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic         dout,
  output logic [L-1:0] bits
);
  generate
    if (L > 1) begin : g_long
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        bits <= '0;
        else if (shift_en) bits <= {bits[L-2:0], din};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        bits <= '0;
        else if (shift_en) bits <= din;
      end
    end
  endgenerate

  assign dout = bits[L-1];
endmodule

// File: rtl/cb_in_sel.sv
module cb_in_sel
  import cb_pkg::*;
#(
  parameter int W    = 6,
  parameter int K    = 3,
  parameter int IDXW = 2,
  parameter int P    = 0
) (
  input  logic [W-1:0]    trk,
  input  logic            en,
  input  logic [IDXW-1:0] idx,
  output logic            pin,
  output logic            hit
);
  always_comb begin
    hit = 1'b0;
    pin = 1'b0;
    for (int k = 0; k < K; k++) begin
      if (en && (idx == IDXW'(k))) begin
        hit = 1'b1;
        pin = trk[track_of(P, k, W)];
      end
    end
  end
endmodule

// File: rtl/cb_trk_drv.sv
module cb_trk_drv
  import cb_pkg::*;
#(
  parameter int W    = 6,
  parameter int NOUT = 2,
  parameter int K    = 3,
  parameter int T    = 0
) (
  input  logic              trk_in,
  input  logic [NOUT-1:0]   pin_out,
  input  logic [NOUT*K-1:0] en_flat,
  output logic              trk_out,
  output logic              drv,
  output logic [NOUT-1:0]   gnt
);
  logic [NOUT-1:0] req;

  genvar q;
  generate
    for (q = 0; q < NOUT; q++) begin : g_req
      localparam int OFF = offset_of(T, q, W);
      if (OFF < K) begin : g_reach
        assign req[q] = en_flat[q*K + OFF];
      end else begin : g_none
        assign req[q] = 1'b0;
      end
    end
  endgenerate

  // Fixed priority: lowest-numbered requesting pin wins the track
  always_comb begin
    gnt     = '0;
    drv     = 1'b0;
    trk_out = trk_in;
    for (int i = 0; i < NOUT; i++) begin
      if (req[i] && !drv) begin
        gnt[i]  = 1'b1;
        drv     = 1'b1;
        trk_out = pin_out[i];
      end
    end
  end
endmodule

// File: rtl/cb_connect_block.sv
module cb_connect_block
  import cb_pkg::*;
#(
  parameter int W      = 6,
  parameter int NIN    = 4,
  parameter int NOUT   = 2,
  parameter int FC_PCT = 50
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_din,
  output logic            cfg_dout,
  input  logic [W-1:0]    trk_in,
  output logic [W-1:0]    trk_out,
  output logic [NIN-1:0]  pin_to_cluster,
  input  logic [NOUT-1:0] pin_from_cluster
);
  localparam int K     = reach_of(W, FC_PCT);
  localparam int IDXW  = idx_width(K);
  localparam int IW    = IDXW + 1;
  localparam int OBASE = NIN * IW;
  localparam int L     = OBASE + NOUT * K;

  // Named internal events for the checker
  logic [L-1:0]      cfg_bits;
  logic [NIN-1:0]    in_hit;
  logic [W-1:0]      trk_drv;
  logic [W*NOUT-1:0] gnt_flat;

  cb_cfg_chain #(.L(L)) i_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en),
    .din      (cfg_din),
    .dout     (cfg_dout),
    .bits     (cfg_bits)
  );

  genvar p, t;
  generate
    for (p = 0; p < NIN; p++) begin : g_in
      cb_in_sel #(.W(W), .K(K), .IDXW(IDXW), .P(p)) i_sel (
        .trk (trk_in),
        .en  (cfg_bits[p*IW + IDXW]),
        .idx (cfg_bits[p*IW +: IDXW]),
        .pin (pin_to_cluster[p]),
        .hit (in_hit[p])
      );
    end

    for (t = 0; t < W; t++) begin : g_trk
      cb_trk_drv #(.W(W), .NOUT(NOUT), .K(K), .T(t)) i_drv (
        .trk_in  (trk_in[t]),
        .pin_out (pin_from_cluster),
        .en_flat (cfg_bits[OBASE +: NOUT*K]),
        .trk_out (trk_out[t]),
        .drv     (trk_drv[t]),
        .gnt     (gnt_flat[t*NOUT +: NOUT])
      );
    end
  endgenerate
endmodule

// File: rtl/cb_connect_block_chk.sv
module cb_connect_block_chk
  import cb_pkg::*;
#(
  parameter int W      = 6,
  parameter int NIN    = 4,
  parameter int NOUT   = 2,
  parameter int FC_PCT = 50
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_en,
  input logic                   cfg_din,
  input logic                   cfg_dout,
  input logic [W-1:0]           trk_in,
  input logic [W-1:0]           trk_out,
  input logic [NIN-1:0]         pin_to_cluster,
  input logic [NOUT-1:0]        pin_from_cluster,
  input logic [NIN*(idx_width(reach_of(W, FC_PCT))+1)
               + NOUT*reach_of(W, FC_PCT)-1:0] cfg_bits,
  input logic [NIN-1:0]         in_hit,
  input logic [W-1:0]           trk_drv,
  input logic [W*NOUT-1:0]      gnt_flat
);
  // R2: shift enters at bit 0, and the chain holds when not enabled
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> cfg_bits[0] == $past(cfg_din));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_bits));

  // R5: a pin without a valid selection stays 0
  p_idle_pin_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_to_cluster & ~in_hit) == '0);

  // R7: undriven tracks pass through
  p_pass_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((trk_out ^ trk_in) & ~trk_drv) == '0);

  // R8: at most one winner per track, present exactly when the track is driven
  genvar t;
  generate
    for (t = 0; t < W; t++) begin : g_t
      p_one_winner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_flat[t*NOUT +: NOUT]));
      p_winner_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trk_drv[t] == (|gnt_flat[t*NOUT +: NOUT]));
    end
  endgenerate
endmodule

bind cb_connect_block cb_connect_block_chk #(
  .W(W), .NIN(NIN), .NOUT(NOUT), .FC_PCT(FC_PCT)
) i_chk (.*);

// File: tb/test_cb_connect_block.sv
`timescale 1ns/1ps
module test_cb_connect_block;
  localparam int W    = 6;
  localparam int NIN  = 4;
  localparam int NOUT = 2;
  localparam int FC   = 50;
  localparam int KB   = (W * FC + 50) / 100;   // 3
  localparam int IWB  = 3;                     // enable + 2-bit index
  localparam int OB   = NIN * IWB;             // 12
  localparam int LB   = OB + NOUT * KB;        // 18

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_en = 1'b0;
  logic            cfg_din = 1'b0;
  logic            cfg_dout;
  logic [W-1:0]    trk_in = '0;
  logic [W-1:0]    trk_out;
  logic [NIN-1:0]  pin_to_cluster;
  logic [NOUT-1:0] pin_from_cluster = '0;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cb_connect_block #(.W(W), .NIN(NIN), .NOUT(NOUT), .FC_PCT(FC)) i_cb_connect_block (
    .clk, .rst_n, .cfg_en, .cfg_din, .cfg_dout,
    .trk_in, .trk_out, .pin_to_cluster, .pin_from_cluster
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Shift a full configuration, first bit sent lands in the top stage
  task automatic load(input logic [LB-1:0] v);
    for (int i = LB - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      cfg_din = v[i];
    end
    @(negedge clk);
    cfg_en  = 1'b0;
    cfg_din = 1'b0;
  endtask

  // Bench model of one input pin
  function automatic logic exp_pin(input logic [LB-1:0] c, input logic [W-1:0] trk, input int p);
    logic [2:0] f;
    int k;
    f = c[p*IWB +: IWB];
    k = int'(f[1:0]);
    if (f[2] && k < KB) return trk[(p + k) % W];
    return 1'b0;
  endfunction

  // Bench model of the whole track vector
  function automatic logic [W-1:0] exp_trk(input logic [LB-1:0] c, input logic [W-1:0] trk,
                                           input logic [NOUT-1:0] po);
    logic [W-1:0] r;
    r = trk;
    for (int t = 0; t < W; t++) begin
      for (int q = NOUT - 1; q >= 0; q--) begin
        int k;
        k = (t + W - q) % W;
        if (k < KB && c[OB + q*KB + k]) r[t] = po[q];
      end
    end
    return r;
  endfunction

  function automatic bit shared(input logic [LB-1:0] c);
    for (int t = 0; t < W; t++) begin
      int hits;
      hits = 0;
      for (int q = 0; q < NOUT; q++) begin
        int k;
        k = (t + W - q) % W;
        if (k < KB && c[OB + q*KB + k]) hits++;
      end
      if (hits > 1) return 1'b1;
    end
    return 1'b0;
  endfunction

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [LB-1:0] cfg;

    // R1: reset state
    repeat (3) @(negedge clk);
    trk_in = 6'h2B; pin_from_cluster = 2'b11; #1;
    chk("R1 pins in reset", 32'(pin_to_cluster), 32'h0);
    chk("R1 tracks in reset", 32'(trk_out), 32'h2B);
    rst_n = 1'b1;
    @(negedge clk);
    trk_in = 6'h14; #1;
    chk("R1 pins after reset", 32'(pin_to_cluster), 32'h0);
    chk("R1 tracks after reset", 32'(trk_out), 32'h14);

    // R3, R4, R5, R9: every input field code on every pin over all track patterns
    for (int p = 0; p < NIN; p++) begin
      for (int f = 0; f < 8; f++) begin
        cfg = '0;
        cfg[p*IWB +: IWB] = 3'(f);
        load(cfg);
        for (int tp = 0; tp < 64; tp++) begin
          trk_in = 6'(tp);
          #1;
          for (int pp = 0; pp < NIN; pp++)
            chk((f[2] && f[1:0] < 2'd3 && pp == p) ? "R3 R4 R9 input select" : "R5 input disabled",
                32'(pin_to_cluster[pp]), 32'(exp_pin(cfg, trk_in, pp)));
        end
      end
    end

    // R6, R7, R8: every output enable combination
    for (int oc = 0; oc < (1 << (NOUT*KB)); oc++) begin
      cfg = '0;
      cfg[OB +: NOUT*KB] = 6'(oc);
      load(cfg);
      for (int tp = 0; tp < 64; tp++) begin
        for (int po = 0; po < 4; po++) begin
          trk_in = 6'(tp);
          pin_from_cluster = 2'(po);
          #1;
          chk(shared(cfg) ? "R8 lowest pin wins" : (oc == 0 ? "R7 pass-through" : "R6 R7 output drive"),
              32'(trk_out), 32'(exp_trk(cfg, trk_in, pin_from_cluster)));
        end
      end
    end

    // R2: serial read-back through cfg_dout
    cfg = 18'h2D5A3;
    load(cfg);
    for (int j = 0; j < LB; j++) begin
      chk("R2 chain read-back", 32'(cfg_dout), 32'(cfg[LB-1-j]));
      cfg_en = 1'b1; cfg_din = 1'b0;
      @(negedge clk);
      cfg_en = 1'b0;
    end

    // R2: hold with cfg_en low
    cfg = {6'b101_011, 3'b100, 3'b110, 3'b101, 3'b111};
    load(cfg);
    cfg_din = 1'b1;
    repeat (5) @(negedge clk);
    trk_in = 6'h35; pin_from_cluster = 2'b01; #1;
    chk("R2 hold pins", 32'(pin_to_cluster),
        32'({exp_pin(cfg, trk_in, 3), exp_pin(cfg, trk_in, 2), exp_pin(cfg, trk_in, 1), exp_pin(cfg, trk_in, 0)}));
    chk("R2 hold tracks", 32'(trk_out), 32'(exp_trk(cfg, trk_in, pin_from_cluster)));
    cfg_din = 1'b0;

    // R1: reset clears a loaded configuration
    rst_n = 1'b0; #1;
    chk("R1 reset clears pins", 32'(pin_to_cluster), 32'h0);
    chk("R1 reset clears tracks", 32'(trk_out), 32'h35);
    chk("R1 reset clears chain out", 32'(cfg_dout), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule